// File: doc/BRIEF.md
# Slave Sync Field Detector

This block sits behind the video input pins of a capture path that follows an external timing source. It samples horizontal sync, vertical sync and an optional field indicator on a pixel-rate enable. Each input passes through its own two-stage synchronizer and then a per-signal polarity bit, which turns all three into active-high form. From the normalized vertical sync it picks one edge, either leading or trailing, as the start of a new field. On that edge it emits a one-clock pulse that downstream vertical counters use as their reset.

At the same edge it decides whether the field that starts is odd or even. Some sources provide a separate field pin. For those, the block reads that pin's normalized level. For sources without one, it looks at the level of the normalized horizontal sync at the chosen vertical edge. A vertical edge that falls inside the short horizontal sync pulse marks an odd field. An edge that falls mid-line marks an even field. A swap bit inverts the result in either mode. The field flag changes only together with the field-start pulse and holds until the next one. All configuration inputs are meant to be static and are changed only while reset is held.

Top module: `sync_field_detect`

## Requirements
- R1: While reset is held and in the clock after it is released, `field_odd` and `field_start` are 0. No `field_start` is produced before the synchronizer and the edge history are filled, which takes three enabled samples after reset.
- R2: `hsync_act`, `vsync_act` and the internal field level equal the raw input sampled two enabled samples earlier, XORed with its polarity bit. A polarity bit of 1 means the input is active-low.
- R3: With `cfg_trail_edge`=0 the inactive-to-active transition of normalized vertical sync starts a field. With `cfg_trail_edge`=1 the active-to-inactive transition does. Each selected transition produces exactly one `field_start`, and the other transition produces none.
- R4: `field_start` is high for exactly one clock. It rises on the clock edge after the enabled sample that reveals the selected vertical edge at the synchronizer output, which is three enabled samples after the raw input changed.
- R5: With `cfg_ext_fld`=0 and `cfg_swap`=0, `field_odd` becomes 1 when normalized horizontal sync is active at the selected vertical edge, and 0 when it is inactive.
- R6: With `cfg_ext_fld`=1 and `cfg_swap`=0, `field_odd` becomes the normalized field indicator (`fld_in` XOR `cfg_fld_inv`, where 1 means odd) at the selected vertical edge. Horizontal sync has no influence on it.
- R7: `cfg_swap`=1 inverts the value written to `field_odd` in both modes.
- R8: `field_odd` changes only in the clock in which `field_start` is high.
- R9: While `pix_en` is low no input is sampled: `hsync_act`, `vsync_act` and `field_odd` hold their values and no `field_start` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel enable; inputs are sampled only when high |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| fld_in | input | 1 | Raw external field indicator |
| cfg_hs_inv | input | 1 | 1: horizontal sync is active-low |
| cfg_vs_inv | input | 1 | 1: vertical sync is active-low |
| cfg_fld_inv | input | 1 | 1: field indicator is inverted (low means odd) |
| cfg_ext_fld | input | 1 | 1: field from `fld_in`; 0: field from horizontal sync level |
| cfg_trail_edge | input | 1 | 1: trailing vertical edge starts a field; 0: leading edge |
| cfg_swap | input | 1 | 1: invert the even/odd result |
| field_odd | output | 1 | Current field is odd |
| field_start | output | 1 | One-clock pulse at the start of a field |
| hsync_act | output | 1 | Synchronized, active-high horizontal sync |
| vsync_act | output | 1 | Synchronized, active-high vertical sync |

## Verification
The embedded assertions check four rules on every cycle. The field-start pulse never lasts two clocks. The field flag never moves without that pulse. No pulse follows a clock in which the pixel enable was low. The normalized syncs stay frozen after such a clock.

Only the bench scenarios can show that the correct vertical edge is chosen, and that the odd/even decision matches the hsync timing or the external pin under every polarity and swap setting. The same holds for the start-up suppression after reset and the two-sample normalization delay. The bench generates whole fields with the vertical edge placed either inside the hsync pulse or mid-line. The edge is placed at least two pixel periods after the hsync edge. The bench then compares every pulse with the value the scoreboard predicted, including a run at half-rate pixel enable.

// File: rtl/sfd_pkg.sv
// Package: shared constants for the slave sync field detector.
// Assumes: at least two synchronizer stages are always used.
package sfd_pkg;
    localparam int SFD_MIN_STAGES = 2;
    localparam int SFD_NUM_INPUTS = 3;
    // Bit positions of the inputs inside the synchronizer vector.
    localparam int SFD_IDX_HS  = 0;
    localparam int SFD_IDX_VS  = 1;
    localparam int SFD_IDX_FLD = 2;
endpackage

// File: rtl/sfd_sync.sv
// Module: sfd_sync
// Passes each raw input through a shift chain that advances only on the
// pixel enable, then applies its polarity bit so every output is active high.
// Assumes: the polarity bits are static outside reset; STAGES >= 2.
module sfd_sync #(
    parameter int N_SIG  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [N_SIG-1:0] raw_in,
    input  logic [N_SIG-1:0] inv_in,
    output logic [N_SIG-1:0] norm_out
);
    localparam int TOP = STAGES - 1;

    generate
        for (genvar g = 0; g < N_SIG; g++) begin : g_chan
            logic [STAGES-1:0] chain;

            // Shift the raw level one stage forward on each pixel enable.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '0;
                end else if (pix_en) begin
                    chain <= {chain[TOP-1:0], raw_in[g]};
                end
            end

            // Normalize the synchronized level to active-high.
            assign norm_out[g] = chain[TOP] ^ inv_in[g];
        end
    endgenerate

    // Outputs stay frozen after a clock without pixel enable.
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_en) |-> $stable(norm_out));
endmodule

// File: rtl/sfd_edge.sv
// Module: sfd_edge
// Detects the selected transition of normalized vertical sync. Detection
// is suppressed until the synchronizer and the one-sample history hold real
// samples, so reset values never look like an edge.
// Assumes: vs_act comes from sfd_sync with the same STAGES.
module sfd_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_en,
    input  logic vs_act,
    input  logic trail_sel,
    output logic edge_hit
);
    localparam int PRIME = STAGES + 1;
    localparam int CW    = $clog2(PRIME + 1);

    logic [CW-1:0] fill_cnt;
    logic          primed;
    logic          vs_prev;
    logic          rise;
    logic          fall;

    // Count enabled samples after reset until the pipeline is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (pix_en && !primed) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    assign primed = (fill_cnt == CW'(PRIME));

    // Keep the previous enabled sample of normalized vertical sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_prev <= 1'b0;
        end else if (pix_en) begin
            vs_prev <= vs_act;
        end
    end

    // Select the leading or trailing transition.
    always_comb begin
        rise     = vs_act & ~vs_prev;
        fall     = ~vs_act & vs_prev;
        edge_hit = pix_en & primed & (trail_sel ? fall : rise);
    end
endmodule

// File: rtl/sfd_field.sv
// Module: sfd_field
// Registers the field-start pulse and decides odd/even at that edge, from
// either the external indicator or the horizontal sync level, then applies
// the swap bit.
// Assumes: edge_hit is already qualified by the pixel enable.
module sfd_field (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_hit,
    input  logic hs_act,
    input  logic fld_act,
    input  logic ext_sel,
    input  logic swap,
    output logic field_start,
    output logic field_odd
);
    logic odd_raw;

    // Pick the field source.
    always_comb begin
        odd_raw = ext_sel ? fld_act : hs_act;
    end

    // Emit the start pulse one clock after the detected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_start <= 1'b0;
        end else begin
            field_start <= edge_hit;
        end
    end

    // Update the field flag only on a detected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_odd <= 1'b0;
        end else if (edge_hit) begin
            field_odd <= odd_raw ^ swap;
        end
    end

    // The flag moves only together with the start pulse.
    assert_flag_moves_with_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> field_start);
endmodule

// File: rtl/sync_field_detect.sv
// Module: sync_field_detect (top)
// Follows external sync: normalizes hsync, vsync and the field indicator,
// produces a field-start pulse on the chosen vsync edge and an odd/even flag.
// Assumes: configuration is changed only while rst_n is low.
module sync_field_detect
    import sfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_en,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic fld_in,
    input  logic cfg_hs_inv,
    input  logic cfg_vs_inv,
    input  logic cfg_fld_inv,
    input  logic cfg_ext_fld,
    input  logic cfg_trail_edge,
    input  logic cfg_swap,
    output logic field_odd,
    output logic field_start,
    output logic hsync_act,
    output logic vsync_act
);
    localparam int STAGES = (SYNC_STAGES < SFD_MIN_STAGES) ? SFD_MIN_STAGES : SYNC_STAGES;

    logic [SFD_NUM_INPUTS-1:0] raw_vec;
    logic [SFD_NUM_INPUTS-1:0] inv_vec;
    logic [SFD_NUM_INPUTS-1:0] norm_vec;
    logic                      edge_hit;

    // Gather the inputs and their polarity bits into vectors.
    always_comb begin
        raw_vec[SFD_IDX_HS]  = hsync_in;
        raw_vec[SFD_IDX_VS]  = vsync_in;
        raw_vec[SFD_IDX_FLD] = fld_in;
        inv_vec[SFD_IDX_HS]  = cfg_hs_inv;
        inv_vec[SFD_IDX_VS]  = cfg_vs_inv;
        inv_vec[SFD_IDX_FLD] = cfg_fld_inv;
    end

    sfd_sync #(.N_SIG(SFD_NUM_INPUTS), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_en   (pix_en),
        .raw_in   (raw_vec),
        .inv_in   (inv_vec),
        .norm_out (norm_vec)
    );

    sfd_edge #(.STAGES(STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_en    (pix_en),
        .vs_act    (norm_vec[SFD_IDX_VS]),
        .trail_sel (cfg_trail_edge),
        .edge_hit  (edge_hit)
    );

    sfd_field u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_hit    (edge_hit),
        .hs_act      (norm_vec[SFD_IDX_HS]),
        .fld_act     (norm_vec[SFD_IDX_FLD]),
        .ext_sel     (cfg_ext_fld),
        .swap        (cfg_swap),
        .field_start (field_start),
        .field_odd   (field_odd)
    );

    assign hsync_act = norm_vec[SFD_IDX_HS];
    assign vsync_act = norm_vec[SFD_IDX_VS];

    // A start pulse never lasts more than one clock.
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !field_start);

    // A start pulse always follows an enabled sample.
    assert_start_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> $past(pix_en));
endmodule

// File: tb/test_sync_field_detect.sv
module test_sync_field_detect;
    localparam int LINE = 64;
    localparam int HSW  = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, pix_en = 1'b0;
    logic hsync_in = 1'b0, vsync_in = 1'b0, fld_in = 1'b0;
    logic cfg_hs_inv = 1'b0, cfg_vs_inv = 1'b0, cfg_fld_inv = 1'b0;
    logic cfg_ext_fld = 1'b0, cfg_trail_edge = 1'b0, cfg_swap = 1'b0;
    logic field_odd, field_start, hsync_act, vsync_act;

    int checks = 0;
    int errors = 0;
    int n_start = 0;
    int r8_viol = 0;
    int exp_q[$];
    logic prev_odd = 1'b0;
    logic vs_drv_prev = 1'b0;
    logic cad = 1'b0;

    sync_field_detect i_sync_field_detect (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .fld_in(fld_in),
        .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv), .cfg_fld_inv(cfg_fld_inv),
        .cfg_ext_fld(cfg_ext_fld), .cfg_trail_edge(cfg_trail_edge), .cfg_swap(cfg_swap),
        .field_odd(field_odd), .field_start(field_start),
        .hsync_act(hsync_act), .vsync_act(vsync_act)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on every start pulse; track flag stability (R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (field_start) begin
                n_start++;
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R4 unexpected field_start actual=1 expected=0");
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(field_odd) == e, "R5/R6/R7", "field_odd at start", field_odd, e);
                end
            end else if (field_odd != prev_odd) begin
                r8_viol++;
            end
            prev_odd = field_odd;
        end else begin
            prev_odd = 1'b0;
        end
    end

    // Drive one pixel sample given active-high levels.
    task automatic drive_sample(input logic h, input logic v, input logic f);
        hsync_in = h ^ cfg_hs_inv;
        vsync_in = v ^ cfg_vs_inv;
        fld_in   = f ^ cfg_fld_inv;
        pix_en   = 1'b1;
        @(posedge clk); #1;
        if (cad) begin
            pix_en = 1'b0;
            @(posedge clk); #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pix_en = 1'b1;
        hsync_in = cfg_hs_inv;
        vsync_in = cfg_vs_inv;
        fld_in = cfg_fld_inv;
        exp_q.delete();
        vs_drv_prev = 1'b0;
        repeat (4) begin @(posedge clk); #1; end
        rst_n = 1'b1;
        @(negedge clk);
        chk(field_odd == 1'b0 && field_start == 1'b0, "R1", "outputs after reset",
            {field_odd, field_start}, 0);
        @(posedge clk); #1;
    endtask

    // Driver: one field; vertical edges placed inside the hsync pulse or mid-line.
    task automatic run_field(input bit in_pulse, input bit f_log, inout int pushes);
        int vpos;
        vpos = LINE + (in_pulse ? 3 : 32);
        for (int n = 0; n < 4 * LINE; n++) begin
            logic h, v;
            h = (n % LINE) < HSW;
            v = (n >= vpos) && (n < vpos + 2 * LINE);
            if (v != vs_drv_prev && (v != cfg_trail_edge)) begin
                exp_q.push_back(int'((cfg_ext_fld ? f_log : h) ^ cfg_swap));
                pushes++;
            end
            vs_drv_prev = v;
            drive_sample(h, v, f_log);
        end
    endtask

    task automatic scenario(input string name, input bit ext, input bit trail, input bit swp,
                            input bit hinv, input bit vinv, input bit finv, input bit cd,
                            input int pat);
        int pushes, s0;
        cfg_ext_fld = ext; cfg_trail_edge = trail; cfg_swap = swp;
        cfg_hs_inv = hinv; cfg_vs_inv = vinv; cfg_fld_inv = finv; cad = cd;
        do_reset();
        pushes = 0;
        s0 = n_start;
        r8_viol = 0;
        for (int i = 0; i < 4; i++) begin
            bit ip;
            ip = ((i + pat) % 2) == 0;
            run_field(ip, !ip, pushes);
        end
        repeat (10) drive_sample(1'b0, 1'b0, 1'b0);
        chk(exp_q.size() == 0, "R4", {name, " pending pulses"}, exp_q.size(), 0);
        chk(n_start - s0 == pushes, "R3", {name, " pulse count"}, n_start - s0, pushes);
        chk(r8_viol == 0, "R8", {name, " flag moved without start"}, r8_viol, 0);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        // R1: idle inverted vsync across reset must not produce a start pulse.
        cfg_vs_inv = 1'b1; cfg_trail_edge = 1'b1; cfg_hs_inv = 1'b1;
        do_reset();
        s0 = n_start;
        repeat (8) drive_sample(1'b0, 1'b0, 1'b0);
        chk(n_start == s0, "R1", "no start during pipeline fill", n_start - s0, 0);
        chk(vsync_act == 1'b0, "R2", "vsync_act idle inverted", vsync_act, 0);
        // R2: active-low hsync shows up after two enabled samples.
        drive_sample(1'b1, 1'b0, 1'b0);
        chk(hsync_act == 1'b0, "R2", "hsync_act after one sample", hsync_act, 0);
        drive_sample(1'b1, 1'b0, 1'b0);
        chk(hsync_act == 1'b1, "R2", "hsync_act after two samples", hsync_act, 1);
        // R9: with pix_en low, toggling raw inputs changes nothing.
        pix_en = 1'b0;
        s0 = n_start;
        for (int k = 0; k < 10; k++) begin
            hsync_in = k[0];
            vsync_in = ~k[0];
            @(posedge clk); #1;
        end
        chk(hsync_act == 1'b1, "R9", "hsync_act held", hsync_act, 1);
        chk(vsync_act == 1'b0, "R9", "vsync_act held", vsync_act, 0);
        chk(n_start == s0 && field_odd == 1'b0, "R9", "no start while disabled",
            n_start - s0, 0);

        scenario("internal leading",  0, 0, 0, 0, 0, 0, 0, 0);   // R3 R5
        scenario("internal trailing", 0, 1, 0, 0, 0, 0, 0, 1);   // R3 R5
        scenario("internal swap",     0, 0, 1, 0, 0, 0, 0, 0);   // R7
        scenario("inverted syncs",    0, 1, 0, 1, 1, 0, 0, 0);   // R2 R5
        scenario("external",          1, 0, 0, 0, 0, 1, 0, 0);   // R6
        scenario("external swap",     1, 1, 1, 0, 1, 0, 0, 1);   // R6 R7
        scenario("half rate enable",  0, 0, 0, 0, 0, 0, 1, 1);   // R4 R9

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule